// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits beside the control path of a 32-bit RISC pipeline. It performs exception entry and the return from an exception handler. When the pipeline raises an exception request, the request carries four things: the exception number, the PC of the instruction involved, a flag that says the instruction sat in a branch delay slot, and the live status register. The block then does the following:

- It records a return PC, choosing between the faulting instruction and the one after it, and correcting for the delay slot.
- It saves the status register.
- It produces the new status word with its delay-slot-exception bit written.
- It pulses a one-cycle redirect toward the handler address. The status register's high-vector bit selects between a low and a high vector base.

A breakpoint trap does not vector. It raises a halt strobe carrying the PC instead. A return request puts the saved status back, with its fixed-one bit forced, and redirects to the saved PC.

All results are registered. They appear on the clock edge that follows the request. The pipeline writes `sr_out` into its status register whenever `sr_wr` pulses. It clears any pending delay-slot state of its own when `dslot_clr` pulses.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `epc_q`, `esr_q`, `eear_q`, `sr_out`, `redirect_pc` and `halt_pc` are 0, and `redirect`, `halt`, `bad_exc`, `sr_wr` and `dslot_clr` are 0.
- R2: For a floating-point exception (number 0xD) or a system call (0xC), `epc_q` becomes `exc_pc`+4, or `exc_pc` when `in_dslot` is 1.
- R3: For a bus error (0x2), alignment (0x6), illegal instruction (0x7) or range (0xB) exception, `epc_q` becomes `exc_pc`, or `exc_pc`-4 when `in_dslot` is 1.
- R4: A reset exception (0x1) vectors normally but leaves `epc_q` unchanged.
- R5: On every vectoring exception (0x1, 0x2, 0x6, 0x7, 0xB, 0xC, 0xD), `esr_q` takes `sr_in`. `sr_out` takes `sr_in` with bit 13 (delay-slot exception) replaced by `in_dslot`. `sr_wr` and `dslot_clr` pulse for one cycle.
- R6: On a vectoring exception, `redirect` pulses for exactly one cycle, with `redirect_pc` = number shifted left by 8, plus 0xF0000000 when `sr_in` bit 14 (high vector) is 1. At most one of `redirect`, `halt` and `bad_exc` is high in any cycle.
- R7: A trap (0xE) pulses `halt` with `halt_pc` = `exc_pc`. It raises no `redirect` or `sr_wr`, and it leaves `epc_q`, `esr_q` and `eear_q` unchanged.
- R8: An illegal-instruction exception loads `eear_q` with `exc_pc`, without any delay-slot correction. Other exceptions leave `eear_q` unchanged.
- R9: A return request (`rfe_req` with no `exc_req`) pulses `redirect` with `redirect_pc` = `epc_q`. It pulses `sr_wr` with `sr_out` = `esr_q` with bit 15 (fixed-one) set.
- R10: Any other exception number pulses `bad_exc`. It raises no `redirect`, `halt` or `sr_wr`, and it leaves `epc_q`, `esr_q` and `eear_q` unchanged.
- R11: When `exc_req` and `rfe_req` are high in the same cycle, only the exception is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request, one cycle |
| exc_num | input | 4 | Exception number |
| exc_pc | input | 32 | PC of the instruction involved |
| in_dslot | input | 1 | Instruction was in a delay slot |
| sr_in | input | 32 | Current status register |
| rfe_req | input | 1 | Return-from-exception request |
| epc_q | output | 32 | Saved exception PC |
| esr_q | output | 32 | Saved status register |
| eear_q | output | 32 | Error effective address |
| sr_out | output | 32 | New status word, valid with sr_wr |
| sr_wr | output | 1 | Status write strobe |
| dslot_clr | output | 1 | Clear pending delay-slot state |
| redirect | output | 1 | Redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| halt | output | 1 | Breakpoint halt strobe |
| halt_pc | output | 32 | PC reported with halt |
| bad_exc | output | 1 | Unknown exception number strobe |

## Verification
The exception number is driven through every defined code and through undefined ones. This separates the following-instruction class, the faulting-instruction class, the reset case, the trap path and the error path by their effect on `epc_q`, `eear_q` and the strobes. The delay-slot flag and the high-vector bit are each toggled under every class. This shows that the PC correction and the vector base are applied per class and are not swapped. Return requests follow exceptions, and also arrive in the same cycle as exceptions. These patterns show that the restored status comes from the saved copy with the fixed-one bit forced, and that the exception wins a collision. Random status words and PCs expose bits that are copied wrongly or taken from the wrong source.

// File: rtl/exc_pkg.sv
package exc_pkg;

   // exception handling classes
   typedef enum logic [2:0] {
      CL_RESET = 3'd0,   // vectors, keeps the saved PC
      CL_FAULT = 3'd1,   // saved PC is the faulting instruction
      CL_NEXT  = 3'd2,   // saved PC is the following instruction
      CL_TRAP  = 3'd3,   // halts, no vector
      CL_BAD   = 3'd4    // unknown number
   } exc_class_e;

   localparam int unsigned EXN_RESET   = 1;
   localparam int unsigned EXN_BUSERR  = 2;
   localparam int unsigned EXN_ALIGN   = 6;
   localparam int unsigned EXN_ILLEGAL = 7;
   localparam int unsigned EXN_RANGE   = 11;
   localparam int unsigned EXN_SYSCALL = 12;
   localparam int unsigned EXN_FPE     = 13;
   localparam int unsigned EXN_TRAP    = 14;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
   import exc_pkg::*;
#(
   parameter int unsigned EXC_W = 4
) (
   input  logic [EXC_W-1:0] num,
   output exc_class_e       cls,
   output logic             is_ill
);

   initial begin
      assert (EXC_W >= 4) else $error("exc_classify: EXC_W must hold code 0xE");
   end

   always_comb begin
      is_ill = 1'b0;
      case (32'(num))
         EXN_RESET:                  cls = CL_RESET;
         EXN_BUSERR, EXN_ALIGN,
         EXN_RANGE:                  cls = CL_FAULT;
         EXN_ILLEGAL: begin
            cls    = CL_FAULT;
            is_ill = 1'b1;
         end
         EXN_SYSCALL, EXN_FPE:       cls = CL_NEXT;
         EXN_TRAP:                   cls = CL_TRAP;
         default:                    cls = CL_BAD;
      endcase
   end

endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
   import exc_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned INSN_BYTES = 4
) (
   input  exc_class_e      cls,
   input  logic [XLEN-1:0] pc,
   input  logic            dslot,
   output logic [XLEN-1:0] epc_val
);

   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   initial begin
      assert (INSN_BYTES > 0) else $error("exc_epc_calc: INSN_BYTES must be nonzero");
   end

   logic [XLEN-1:0] base_pc;

   always_comb begin
      base_pc = (cls == CL_NEXT) ? pc + STEP : pc;
      epc_val = dslot ? base_pc - STEP : base_pc;
   end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
   parameter int unsigned     XLEN      = 32,
   parameter int unsigned     EXC_W     = 4,
   parameter int unsigned     VEC_SHIFT = 8,
   parameter bit              HI_VEC_EN = 1'b1,
   parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000
) (
   input  logic [EXC_W-1:0] num,
   input  logic             hi_sel,
   output logic [XLEN-1:0]  vec
);

   initial begin
      assert (EXC_W + VEC_SHIFT <= XLEN)
         else $error("exc_vector_gen: vector offset exceeds XLEN");
   end

   logic [XLEN-1:0] offs;
   assign offs = XLEN'(num) << VEC_SHIFT;

   generate
      if (HI_VEC_EN) begin : g_hi
         assign vec = offs + (hi_sel ? HI_BASE : '0);
      end else begin : g_lo
         logic unused_sel;
         assign unused_sel = hi_sel;
         assign vec        = offs;
      end
   endgenerate

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_pkg::*;
#(
   parameter int unsigned     XLEN       = 32,
   parameter int unsigned     EXC_W      = 4,
   parameter int unsigned     SR_W       = 32,
   parameter int unsigned     VEC_SHIFT  = 8,
   parameter int unsigned     INSN_BYTES = 4,
   parameter int unsigned     DSX_BIT    = 13,
   parameter int unsigned     HV_BIT     = 14,
   parameter int unsigned     FO_BIT     = 15,
   parameter bit              HI_VEC_EN  = 1'b1,
   parameter logic [XLEN-1:0] HI_BASE    = 32'hF000_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exc_req,
   input  logic [EXC_W-1:0] exc_num,
   input  logic [XLEN-1:0]  exc_pc,
   input  logic             in_dslot,
   input  logic [SR_W-1:0]  sr_in,
   input  logic             rfe_req,
   output logic [XLEN-1:0]  epc_q,
   output logic [SR_W-1:0]  esr_q,
   output logic [XLEN-1:0]  eear_q,
   output logic [SR_W-1:0]  sr_out,
   output logic             sr_wr,
   output logic             dslot_clr,
   output logic             redirect,
   output logic [XLEN-1:0]  redirect_pc,
   output logic             halt,
   output logic [XLEN-1:0]  halt_pc,
   output logic             bad_exc
);

   initial begin
      assert (DSX_BIT < SR_W && HV_BIT < SR_W && FO_BIT < SR_W)
         else $error("exc_entry_ctrl: status bit index out of range");
   end

   exc_class_e      cls;
   logic            is_ill;
   logic [XLEN-1:0] epc_val;
   logic [XLEN-1:0] vec;
   logic [SR_W-1:0] entry_sr;
   logic [SR_W-1:0] rfe_sr;

   exc_classify #(.EXC_W(EXC_W)) u_cls (
      .num    (exc_num),
      .cls    (cls),
      .is_ill (is_ill)
   );

   exc_epc_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
      .cls     (cls),
      .pc      (exc_pc),
      .dslot   (in_dslot),
      .epc_val (epc_val)
   );

   exc_vector_gen #(
      .XLEN(XLEN), .EXC_W(EXC_W), .VEC_SHIFT(VEC_SHIFT),
      .HI_VEC_EN(HI_VEC_EN), .HI_BASE(HI_BASE)
   ) u_vec (
      .num    (exc_num),
      .hi_sel (sr_in[HV_BIT]),
      .vec    (vec)
   );

   always_comb begin
      entry_sr          = sr_in;
      entry_sr[DSX_BIT] = in_dslot;
      rfe_sr            = esr_q;
      rfe_sr[FO_BIT]    = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_q       <= '0;
         esr_q       <= '0;
         eear_q      <= '0;
         sr_out      <= '0;
         sr_wr       <= 1'b0;
         dslot_clr   <= 1'b0;
         redirect    <= 1'b0;
         redirect_pc <= '0;
         halt        <= 1'b0;
         halt_pc     <= '0;
         bad_exc     <= 1'b0;
      end else begin
         sr_wr     <= 1'b0;
         dslot_clr <= 1'b0;
         redirect  <= 1'b0;
         halt      <= 1'b0;
         bad_exc   <= 1'b0;
         if (exc_req) begin
            case (cls)
               CL_TRAP: begin
                  halt    <= 1'b1;
                  halt_pc <= exc_pc;
               end
               CL_BAD: bad_exc <= 1'b1;
               default: begin
                  redirect    <= 1'b1;
                  redirect_pc <= vec;
                  esr_q       <= sr_in;
                  sr_out      <= entry_sr;
                  sr_wr       <= 1'b1;
                  dslot_clr   <= 1'b1;
                  if (cls != CL_RESET) epc_q <= epc_val;
                  if (is_ill) eear_q <= exc_pc;
               end
            endcase
         end else if (rfe_req) begin
            redirect    <= 1'b1;
            redirect_pc <= epc_q;
            sr_out      <= rfe_sr;
            sr_wr       <= 1'b1;
         end
      end
   end

   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({redirect, halt, bad_exc}));

   // R4
   reset_epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && 32'(exc_num) == EXN_RESET) |=> $stable(epc_q));

   // R5
   esr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && cls != CL_TRAP && cls != CL_BAD)
         |=> (esr_q == $past(sr_in)) && (sr_out[DSX_BIT] == $past(in_dslot)) && dslot_clr);

   // R7
   trap_no_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req && 32'(exc_num) == EXN_TRAP) |=> halt && !sr_wr && $stable(esr_q));

   // R9
   rfe_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe_req && !exc_req)
         |=> redirect && (redirect_pc == $past(epc_q)) && sr_out[FO_BIT]);

   // R10
   bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_exc |-> !sr_wr && !dslot_clr);

endmodule

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        exc_req;
   logic [3:0]  exc_num;
   logic [31:0] exc_pc;
   logic        in_dslot;
   logic [31:0] sr_in;
   logic        rfe_req;
   logic [31:0] epc_q, esr_q, eear_q, sr_out, redirect_pc, halt_pc;
   logic        sr_wr, dslot_clr, redirect, halt, bad_exc;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // bench model state
   logic [31:0] m_epc, m_esr, m_eear;

   always #2 clk = ~clk;

   exc_entry_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_num(exc_num),
      .exc_pc(exc_pc), .in_dslot(in_dslot), .sr_in(sr_in), .rfe_req(rfe_req),
      .epc_q(epc_q), .esr_q(esr_q), .eear_q(eear_q), .sr_out(sr_out),
      .sr_wr(sr_wr), .dslot_clr(dslot_clr), .redirect(redirect),
      .redirect_pc(redirect_pc), .halt(halt), .halt_pc(halt_pc), .bad_exc(bad_exc)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %08h expected %08h", tag, act, exp);
      end
   endtask

   function automatic int cls_of(input logic [3:0] n);
      case (n)
         4'h1:                      return 0;  // reset
         4'h2, 4'h6, 4'h7, 4'hB:    return 1;  // faulting
         4'hC, 4'hD:                return 2;  // following
         4'hE:                      return 3;  // trap
         default:                   return 4;  // unknown
      endcase
   endfunction

   function automatic logic [31:0] exp_vec(input logic [3:0] n, input logic [31:0] sr);
      return ({28'd0, n} << 8) + (sr[14] ? 32'hF000_0000 : 32'h0);
   endfunction

   function automatic logic [31:0] exp_epc(input int c, input logic [31:0] pc, input logic ds);
      logic [31:0] b;
      b = (c == 2) ? pc + 32'd4 : pc;
      return ds ? b - 32'd4 : b;
   endfunction

   task automatic do_exc(input logic [3:0] n, input logic [31:0] pc, input logic ds,
                         input logic [31:0] sr, input logic also_rfe);
      int c;
      logic [31:0] esr_sr;
      c = cls_of(n);
      @(negedge clk);
      exc_req = 1'b1; exc_num = n; exc_pc = pc; in_dslot = ds; sr_in = sr;
      rfe_req = also_rfe;
      @(negedge clk);
      exc_req = 1'b0; rfe_req = 1'b0;
      if (c <= 2) begin
         if (c == 2) m_epc = exp_epc(c, pc, ds);        // R2
         else if (c == 1) m_epc = exp_epc(c, pc, ds);   // R3
         if (n == 4'h7) m_eear = pc;                    // R8
         m_esr = sr;
         esr_sr = sr; esr_sr[13] = ds;
         chk(also_rfe ? "R11 redirect_pc" : "R6 redirect_pc", redirect_pc, exp_vec(n, sr));
         chk("R6 redirect", {31'd0, redirect}, 32'd1);
         chk("R5 sr_out", sr_out, esr_sr);
         chk("R5 sr_wr", {31'd0, sr_wr}, 32'd1);
         chk("R5 dslot_clr", {31'd0, dslot_clr}, 32'd1);
         chk("R7 halt idle", {31'd0, halt}, 32'd0);
      end else if (c == 3) begin
         chk("R7 halt", {31'd0, halt}, 32'd1);
         chk("R7 halt_pc", halt_pc, pc);
         chk("R7 no redirect", {31'd0, redirect}, 32'd0);
         chk("R7 no sr_wr", {31'd0, sr_wr}, 32'd0);
      end else begin
         chk("R10 bad_exc", {31'd0, bad_exc}, 32'd1);
         chk("R10 no redirect", {31'd0, redirect}, 32'd0);
         chk("R10 no halt", {31'd0, halt}, 32'd0);
         chk("R10 no sr_wr", {31'd0, sr_wr}, 32'd0);
      end
      chk(c == 0 ? "R4 epc" : (c == 2 ? "R2 epc" : "R3 epc"), epc_q, m_epc);
      chk("R5 esr", esr_q, m_esr);
      chk("R8 eear", eear_q, m_eear);
   endtask

   task automatic do_rfe();
      logic [31:0] exp_sr;
      exp_sr = m_esr; exp_sr[15] = 1'b1;
      @(negedge clk);
      rfe_req = 1'b1;
      @(negedge clk);
      rfe_req = 1'b0;
      chk("R9 redirect", {31'd0, redirect}, 32'd1);
      chk("R9 redirect_pc", redirect_pc, m_epc);
      chk("R9 sr_out", sr_out, exp_sr);
      chk("R9 sr_wr", {31'd0, sr_wr}, 32'd1);
      chk("R9 esr kept", esr_q, m_esr);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [3:0] codes [8] = '{4'h1, 4'h2, 4'h6, 4'h7, 4'hB, 4'hC, 4'hD, 4'hE};
      void'($urandom(32'd1234));
      rst_n = 1'b0; exc_req = 1'b0; exc_num = '0; exc_pc = '0; in_dslot = 1'b0;
      sr_in = '0; rfe_req = 1'b0;
      m_epc = '0; m_esr = '0; m_eear = '0;
      repeat (3) @(negedge clk);
      chk("R1 epc", epc_q, 32'd0);
      chk("R1 esr", esr_q, 32'd0);
      chk("R1 strobes", {27'd0, redirect, halt, bad_exc, sr_wr, dslot_clr}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {27'd0, redirect, halt, bad_exc, sr_wr, dslot_clr}, 32'd0);
      chk("R1 eear", eear_q, 32'd0);

      // directed corner cases
      do_exc(4'hD, 32'h0000_1000, 1'b0, 32'h0000_8001, 1'b0);  // R2 plain
      do_exc(4'hC, 32'h0000_2000, 1'b1, 32'h0000_4000, 1'b0);  // R2 delay slot, high vector
      @(negedge clk);
      chk("R6 single cycle", {31'd0, redirect}, 32'd0);
      do_exc(4'h2, 32'h0000_3000, 1'b1, 32'h0000_0000, 1'b0);  // R3 delay slot
      do_exc(4'h7, 32'h0000_4004, 1'b1, 32'h0000_2000, 1'b0);  // R8 uncorrected pc
      do_exc(4'h1, 32'h0000_5000, 1'b0, 32'h0000_4000, 1'b0);  // R4
      do_exc(4'hE, 32'h0000_6000, 1'b0, 32'hFFFF_FFFF, 1'b0);  // R7
      do_exc(4'h3, 32'h0000_7000, 1'b0, 32'h1234_5678, 1'b0);  // R10
      do_exc(4'hF, 32'h0000_7100, 1'b1, 32'h0000_0000, 1'b0);  // R10
      do_rfe();                                                // R9
      do_exc(4'hB, 32'h0000_8000, 1'b0, 32'h0000_0001, 1'b1);  // R11
      do_rfe();

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [3:0]  n;
         logic [31:0] pc, sr;
         n  = ($urandom % 4 == 0) ? 4'($urandom) : codes[$urandom % 8];
         pc = {$urandom, 2'b00} >> 2 << 2;
         sr = $urandom;
         if ($urandom % 5 == 0) do_rfe();
         else do_exc(n, pc, 1'($urandom), sr, ($urandom % 8 == 0) ? 1'b1 : 1'b0);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule